// File: doc/BRIEF.md
# Banked UART Register Access Decoder

This block is the host-side register file for an enhanced 16550-class serial port. The host has a 3-bit address, separate read and write strobes and an 8-bit data bus. Those eight addresses reach about twenty registers. The register behind an address depends on the live contents of three stored registers:

- the line control register,
- the enhanced feature register (bit 4 is the enhanced enable),
- the modem control register.

The block holds every configuration register with its reset value and drives each one out as a port for the neighbouring serial engine, FIFOs and baud generator. Status words are only multiplexed onto the read bus; they are not stored here. These are the line status, modem status, interrupt identification and FIFO-ready words, plus the received byte.

A write to the transmit holding address produces a one-cycle push strobe with the byte. A read of the receive holding address produces a one-cycle pop strobe. The two FIFO-clear bits of the FIFO control word become one-cycle pulses and are not kept. Some control bits can be written only while the enhanced enable is set.

All state uses a synchronous active-high reset. Read data is registered: it appears one clock after the read strobe and then holds until the next read.

Top module: `uart_bank_regs`

## Requirements
- R1: After reset the configuration outputs and read-back take these values. Line control (lcr_q) is 0x1D. Alternate function (afr_q) is 0x10. First and second XON characters (xon1_q, xon2_q) are 0xFF and 0xEF. First and second XOFF characters (xoff1_q, xoff2_q) are both 0xFF. Every other stored register is 0x00.
- R2: With line control bit 7 at 0, address 0 works as follows. A read returns rx_data and pulses rx_pop for one cycle. A write sets tx_data to the byte and pulses tx_push for one cycle.
- R3: With line control bit 7 at 1, address 0 is the low divisor byte and address 1 is the high divisor byte. Writes there leave tx_push at 0 and leave the interrupt enable register unchanged.
- R4: With line control exactly 0xBF, the addresses map as follows. Address 2 is the enhanced feature register. Address 4 is the first XON character and address 5 the second. Address 6 is the first XOFF character and address 7 the second. Address 3 stays the line control register.
- R5: When line control bits [7:5] are 3'b100, address 2 reads and writes the alternate function register.
- R6: When enhanced bit 4 and modem control bit 6 are both 1, address 6 is the transmission control register and address 7 the trigger level register. Otherwise, address 6 reads msr_in and address 7 is the scratch register (subject to R9 and R10).
- R7: While enhanced bit 4 is 0, writes leave three fields unchanged: interrupt enable [7:4], FIFO control [5:4] and modem control [7:5]. While it is 1 these fields take the written value.
- R8: In the normal bank, a read of address 2 returns iir_in. A write there stores the FIFO control word. Written bit 1 pulses fifo_rst_rx and bit 2 pulses fifo_rst_tx, each for one cycle. fcr_q[2:1] always read 0.
- R9: The fractional divisor register takes address 7 when three conditions hold: line control bit 7 is 1, line control is not 0xBF, and enhanced bit 4 is 1. Its bit 6 always reads 0. At address 7 the priority order is: fractional divisor, then trigger level, then FIFO-ready, then scratch.
- R10: A read of address 7 returns fifo_rdy_in when modem control bit 4 is 0 and bit 2 is 1, unless R9 gives the address to a higher-priority register. A write in that state goes to the scratch register.
- R11: Outside the 0xBF bank, address 3 reads line control, address 4 reads modem control and address 5 reads lsr_in. rdata changes only on the clock edge where rd_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rx_data | input | 8 | Received byte at the head of the receive FIFO |
| lsr_in | input | 8 | Line status word |
| msr_in | input | 8 | Modem status word |
| iir_in | input | 8 | Interrupt identification word |
| fifo_rdy_in | input | 8 | FIFO-ready status word |
| rx_pop | output | 1 | One-cycle pulse on a receive holding read |
| tx_push | output | 1 | One-cycle pulse on a transmit holding write |
| tx_data | output | 8 | Byte written to the transmit holding address |
| fifo_rst_rx | output | 1 | One-cycle receive FIFO clear |
| fifo_rst_tx | output | 1 | One-cycle transmit FIFO clear |
| lcr_q | output | 8 | Line control register |
| ier_q | output | 8 | Interrupt enable register |
| fcr_q | output | 8 | Stored FIFO control bits |
| mcr_q | output | 8 | Modem control register |
| efr_q | output | 8 | Enhanced feature register |
| afr_q | output | 8 | Alternate function register |
| dll_q | output | 8 | Divisor low byte |
| dlh_q | output | 8 | Divisor high byte |
| dlf_q | output | 8 | Fractional divisor |
| xon1_q | output | 8 | First XON character |
| xon2_q | output | 8 | Second XON character |
| xoff1_q | output | 8 | First XOFF character |
| xoff2_q | output | 8 | Second XOFF character |
| tcr_q | output | 8 | Transmission control register |
| tlr_q | output | 8 | Trigger level register |

## Verification
The bench builds the block with its default reset-value parameters: line control 0x1D, XON pair 0xFF/0xEF, XOFF pair 0xFF and alternate function 0x10. Because of this, the reset read-back checks hit the values a host driver expects. Starting from those defaults, the bench walks line control through four banks: the normal bank, 0x80 (AFR prefix), 0xBF and 0x83. It toggles the enhanced enable and modem control bits 6, 4 and 2 along the way.

This reaches every bank and the four-way priority at address 7. It also exercises the write-protected fields both before and after the enhanced enable is set.

// File: rtl/uart_bank_pkg.sv
package uart_bank_pkg;
  localparam int DW        = 8;
  localparam int AW        = 3;
  localparam int NCFG      = 16;
  localparam int SELW      = 5;
  localparam logic [DW-1:0] LCR_MAGIC = 8'hBF;

  // entries below NCFG are stored registers, the rest are pass-through
  typedef enum logic [SELW-1:0] {
    S_IER = 5'd0, S_FCR, S_LCR, S_MCR, S_SPR, S_DLL, S_DLH, S_AFR,
    S_EFR, S_XON1, S_XON2, S_XOFF1, S_XOFF2, S_TCR, S_TLR, S_DLF,
    S_HOLD, S_LSR, S_MSR, S_FRDY
  } sel_e;
endpackage

// File: rtl/uart_bank_decode.sv
module uart_bank_decode
  import uart_bank_pkg::*;
(
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] lcr,
  input  logic          enh_en,
  input  logic          mcr_bank,
  input  logic          mcr_loop,
  input  logic          mcr_frdy,
  output sel_e          sel
);
  logic magic, dlab, alt_pfx, tcr_en, dlf_en, frdy_en;

  always_comb begin
    magic   = (lcr == LCR_MAGIC);
    dlab    = lcr[DW-1];
    alt_pfx = (lcr[DW-1:DW-3] == 3'b100);
    tcr_en  = enh_en && mcr_bank;
    dlf_en  = dlab && !magic && enh_en;
    frdy_en = !mcr_loop && mcr_frdy;
  end

  always_comb begin
    sel = S_SPR;
    case (addr)
      3'd0: sel = dlab ? S_DLL : S_HOLD;
      3'd1: sel = dlab ? S_DLH : S_IER;
      3'd2: begin
        if (magic)        sel = S_EFR;
        else if (alt_pfx) sel = S_AFR;
        else              sel = S_FCR;
      end
      3'd3: sel = S_LCR;
      3'd4: sel = magic ? S_XON1 : S_MCR;
      3'd5: sel = magic ? S_XON2 : S_LSR;
      3'd6: begin
        if (magic)       sel = S_XOFF1;
        else if (tcr_en) sel = S_TCR;
        else             sel = S_MSR;
      end
      default: begin
        if (magic)        sel = S_XOFF2;
        else if (dlf_en)  sel = S_DLF;
        else if (tcr_en)  sel = S_TLR;
        else if (frdy_en) sel = S_FRDY;
        else              sel = S_SPR;
      end
    endcase
  end
endmodule

// File: rtl/uart_bank_regfile.sv
module uart_bank_regfile
  import uart_bank_pkg::*;
#(
  parameter logic [DW-1:0] RST_LCR  = 8'h1D,
  parameter logic [DW-1:0] RST_XON1 = 8'hFF,
  parameter logic [DW-1:0] RST_XON2 = 8'hEF,
  parameter logic [DW-1:0] RST_XOFF = 8'hFF,
  parameter logic [DW-1:0] RST_AFR  = 8'h10
)(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  sel_e                      wsel,
  input  logic [DW-1:0]             wdata,
  output logic [NCFG-1:0][DW-1:0]   cfg_q
);
  function automatic logic [DW-1:0] rst_of(input int idx);
    case (idx)
      int'(S_LCR):   rst_of = RST_LCR;
      int'(S_XON1):  rst_of = RST_XON1;
      int'(S_XON2):  rst_of = RST_XON2;
      int'(S_XOFF1): rst_of = RST_XOFF;
      int'(S_XOFF2): rst_of = RST_XOFF;
      int'(S_AFR):   rst_of = RST_AFR;
      default:       rst_of = '0;
    endcase
  endfunction

  // bits a write may change; guarded fields open only with enhanced enable
  function automatic logic [DW-1:0] mask_of(input int idx, input logic enh);
    case (idx)
      int'(S_IER): mask_of = enh ? 8'hFF : 8'h0F;
      int'(S_FCR): mask_of = enh ? 8'hF9 : 8'hC9;
      int'(S_MCR): mask_of = enh ? 8'hFF : 8'h1F;
      int'(S_DLF): mask_of = 8'hBF;
      default:     mask_of = 8'hFF;
    endcase
  endfunction

  logic enh;
  assign enh = cfg_q[int'(S_EFR)][4];

  for (genvar i = 0; i < NCFG; i++) begin : g_cell
    localparam logic [DW-1:0] RV = rst_of(i);
    logic [DW-1:0] m;
    assign m = mask_of(i, enh);
    always_ff @(posedge clk) begin
      if (rst)
        cfg_q[i] <= RV;
      else if (wr_en && (wsel == sel_e'(i)))
        cfg_q[i] <= (cfg_q[i] & ~m) | (wdata & m);
    end
  end
endmodule

// File: rtl/uart_bank_regs.sv
module uart_bank_regs
  import uart_bank_pkg::*;
#(
  parameter logic [7:0] RST_LCR  = 8'h1D,
  parameter logic [7:0] RST_XON1 = 8'hFF,
  parameter logic [7:0] RST_XON2 = 8'hEF,
  parameter logic [7:0] RST_XOFF = 8'hFF,
  parameter logic [7:0] RST_AFR  = 8'h10
)(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] rx_data,
  input  logic [7:0] lsr_in,
  input  logic [7:0] msr_in,
  input  logic [7:0] iir_in,
  input  logic [7:0] fifo_rdy_in,
  output logic       rx_pop,
  output logic       tx_push,
  output logic [7:0] tx_data,
  output logic       fifo_rst_rx,
  output logic       fifo_rst_tx,
  output logic [7:0] lcr_q,
  output logic [7:0] ier_q,
  output logic [7:0] fcr_q,
  output logic [7:0] mcr_q,
  output logic [7:0] efr_q,
  output logic [7:0] afr_q,
  output logic [7:0] dll_q,
  output logic [7:0] dlh_q,
  output logic [7:0] dlf_q,
  output logic [7:0] xon1_q,
  output logic [7:0] xon2_q,
  output logic [7:0] xoff1_q,
  output logic [7:0] xoff2_q,
  output logic [7:0] tcr_q,
  output logic [7:0] tlr_q
);
  logic [NCFG-1:0][DW-1:0] cfg_q;
  sel_e sel, wsel;
  logic [DW-1:0] rd_mux;

  uart_bank_decode u_dec (
    .addr     (addr),
    .lcr      (cfg_q[int'(S_LCR)]),
    .enh_en   (cfg_q[int'(S_EFR)][4]),
    .mcr_bank (cfg_q[int'(S_MCR)][6]),
    .mcr_loop (cfg_q[int'(S_MCR)][4]),
    .mcr_frdy (cfg_q[int'(S_MCR)][2]),
    .sel      (sel)
  );

  // the FIFO-ready word is read-only; writes in that state land in scratch
  assign wsel = (sel == S_FRDY) ? S_SPR : sel;

  uart_bank_regfile #(
    .RST_LCR (RST_LCR), .RST_XON1(RST_XON1), .RST_XON2(RST_XON2),
    .RST_XOFF(RST_XOFF), .RST_AFR (RST_AFR)
  ) u_rf (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_en),
    .wsel  (wsel),
    .wdata (wdata),
    .cfg_q (cfg_q)
  );

  always_comb begin
    case (sel)
      S_HOLD:  rd_mux = rx_data;
      S_FCR:   rd_mux = iir_in;
      S_LSR:   rd_mux = lsr_in;
      S_MSR:   rd_mux = msr_in;
      S_FRDY:  rd_mux = fifo_rdy_in;
      default: rd_mux = cfg_q[sel[3:0]];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata       <= '0;
      rx_pop      <= 1'b0;
      tx_push     <= 1'b0;
      tx_data     <= '0;
      fifo_rst_rx <= 1'b0;
      fifo_rst_tx <= 1'b0;
    end else begin
      if (rd_en) rdata <= rd_mux;
      rx_pop      <= rd_en && (sel == S_HOLD);
      tx_push     <= wr_en && (sel == S_HOLD);
      if (wr_en && (sel == S_HOLD)) tx_data <= wdata;
      fifo_rst_rx <= wr_en && (sel == S_FCR) && wdata[1];
      fifo_rst_tx <= wr_en && (sel == S_FCR) && wdata[2];
    end
  end

  assign lcr_q   = cfg_q[int'(S_LCR)];
  assign ier_q   = cfg_q[int'(S_IER)];
  assign fcr_q   = cfg_q[int'(S_FCR)];
  assign mcr_q   = cfg_q[int'(S_MCR)];
  assign efr_q   = cfg_q[int'(S_EFR)];
  assign afr_q   = cfg_q[int'(S_AFR)];
  assign dll_q   = cfg_q[int'(S_DLL)];
  assign dlh_q   = cfg_q[int'(S_DLH)];
  assign dlf_q   = cfg_q[int'(S_DLF)];
  assign xon1_q  = cfg_q[int'(S_XON1)];
  assign xon2_q  = cfg_q[int'(S_XON2)];
  assign xoff1_q = cfg_q[int'(S_XOFF1)];
  assign xoff2_q = cfg_q[int'(S_XOFF2)];
  assign tcr_q   = cfg_q[int'(S_TCR)];
  assign tlr_q   = cfg_q[int'(S_TLR)];
endmodule

// File: rtl/uart_bank_chk.sv
module uart_bank_chk #(
  parameter logic [7:0] RST_LCR = 8'h1D
)(
  input logic       clk,
  input logic       rst,
  input logic [2:0] addr,
  input logic       wr_en,
  input logic [7:0] wdata,
  input logic [7:0] lcr_q,
  input logic [7:0] efr_q,
  input logic [7:0] ier_q,
  input logic [7:0] mcr_q,
  input logic [7:0] dlf_q,
  input logic       tx_push,
  input logic       fifo_rst_rx,
  input logic       fifo_rst_tx
);
  assert_lcr_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> lcr_q == RST_LCR);

  assert_thr_push_R2: assert property (@(posedge clk) disable iff (rst)
    tx_push |-> $past(wr_en && addr == 3'd0 && !lcr_q[7]));

  assert_ier_guard_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 3'd1 && !lcr_q[7] && !efr_q[4]) |=> $stable(ier_q[7:4]));

  assert_mcr_guard_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 3'd4 && lcr_q != 8'hBF && !efr_q[4]) |=> $stable(mcr_q[7:5]));

  assert_fcr_rx_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    fifo_rst_rx |-> $past(wr_en && addr == 3'd2 && wdata[1]));

  assert_fcr_tx_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    fifo_rst_tx |-> $past(wr_en && addr == 3'd2 && wdata[2]));

  assert_dlf_reserved_R9: assert property (@(posedge clk) disable iff (rst)
    dlf_q[6] == 1'b0);
endmodule

bind uart_bank_regs uart_bank_chk #(.RST_LCR(RST_LCR)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
  .lcr_q(lcr_q), .efr_q(efr_q), .ier_q(ier_q), .mcr_q(mcr_q),
  .dlf_q(dlf_q), .tx_push(tx_push), .fifo_rst_rx(fifo_rst_rx),
  .fifo_rst_tx(fifo_rst_tx)
);

// File: tb/sim_uart_bank_regs.sv
`timescale 1ns/1ps
module sim_uart_bank_regs;
  logic clk = 1'b0, rst = 1'b1;
  logic [2:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic [7:0] rx_data = 8'h5A, lsr_in = 8'h60, msr_in = 8'hF0;
  logic [7:0] iir_in = 8'h01, fifo_rdy_in = 8'h11;
  logic rx_pop, tx_push, fifo_rst_rx, fifo_rst_tx;
  logic [7:0] tx_data, lcr_q, ier_q, fcr_q, mcr_q, efr_q, afr_q, dll_q, dlh_q;
  logic [7:0] dlf_q, xon1_q, xon2_q, xoff1_q, xoff2_q, tcr_q, tlr_q;

  always #10 clk = ~clk;

  uart_bank_regs u0 (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .rx_data(rx_data), .lsr_in(lsr_in),
    .msr_in(msr_in), .iir_in(iir_in), .fifo_rdy_in(fifo_rdy_in),
    .rx_pop(rx_pop), .tx_push(tx_push), .tx_data(tx_data),
    .fifo_rst_rx(fifo_rst_rx), .fifo_rst_tx(fifo_rst_tx),
    .lcr_q(lcr_q), .ier_q(ier_q), .fcr_q(fcr_q), .mcr_q(mcr_q),
    .efr_q(efr_q), .afr_q(afr_q), .dll_q(dll_q), .dlh_q(dlh_q),
    .dlf_q(dlf_q), .xon1_q(xon1_q), .xon2_q(xon2_q), .xoff1_q(xoff1_q),
    .xoff2_q(xoff2_q), .tcr_q(tcr_q), .tlr_q(tlr_q)
  );

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic rd_seen = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // driver: issue read and push the expected byte to the scoreboard
  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    @(negedge clk); addr = a; rd_en = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); rd_en = 1'b0;
  endtask

  always @(posedge clk) rd_seen <= rd_en;

  // monitor: compare registered read data one cycle after the strobe
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) check(1'b0, "scoreboard underflow", rdata, 8'h00);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rdata == e, t, rdata, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset values
    check(lcr_q == 8'h1D, "R1 lcr reset", lcr_q, 8'h1D);
    check(afr_q == 8'h10, "R1 afr reset", afr_q, 8'h10);
    check(xon1_q == 8'hFF, "R1 xon1 reset", xon1_q, 8'hFF);
    check(xon2_q == 8'hEF, "R1 xon2 reset", xon2_q, 8'hEF);
    check(xoff1_q == 8'hFF && xoff2_q == 8'hFF, "R1 xoff reset", xoff2_q, 8'hFF);
    check(ier_q == 8'h00 && mcr_q == 8'h00 && efr_q == 8'h00, "R1 zero regs", ier_q, 8'h00);
    check(rdata == 8'h00, "R1 rdata reset", rdata, 8'h00);
    rd(3'd3, 8'h1D, "R11 lcr read");
    rd(3'd5, 8'h60, "R11 lsr read");
    rd(3'd4, 8'h00, "R11 mcr read");
    rd(3'd2, 8'h01, "R8 iir read");
    rd(3'd6, 8'hF0, "R6 msr read");
    // R11 rdata holds without a read strobe
    lsr_in = 8'h61;
    @(negedge clk);
    check(rdata == 8'hF0, "R11 rdata hold", rdata, 8'hF0);
    // R2 receive and transmit holding
    rd(3'd0, 8'h5A, "R2 rhr read");
    check(rx_pop == 1'b1, "R2 rx_pop pulse", {7'd0, rx_pop}, 8'h01);
    @(negedge clk);
    check(rx_pop == 1'b0, "R2 rx_pop clears", {7'd0, rx_pop}, 8'h00);
    wr(3'd0, 8'hA5);
    check(tx_push == 1'b1 && tx_data == 8'hA5, "R2 tx push", tx_data, 8'hA5);
    @(negedge clk);
    check(tx_push == 1'b0, "R2 tx_push clears", {7'd0, tx_push}, 8'h00);
    // R7 guarded fields while enhanced off
    wr(3'd1, 8'hFF);
    rd(3'd1, 8'h0F, "R7 ier guard");
    wr(3'd4, 8'hE4);
    check(mcr_q == 8'h04, "R7 mcr guard", mcr_q, 8'h04);
    // R10 FIFO-ready read; write goes to scratch
    wr(3'd7, 8'h3C);
    rd(3'd7, 8'h11, "R10 fifo ready read");
    wr(3'd4, 8'h00);
    rd(3'd7, 8'h3C, "R6 scratch read");
    // R8 FCR pulses, R7 FCR guard
    wr(3'd2, 8'hFF);
    check(fifo_rst_rx && fifo_rst_tx, "R8 fifo clear pulses", {6'd0, fifo_rst_tx, fifo_rst_rx}, 8'h03);
    check(fcr_q == 8'hC9, "R7 fcr guard", fcr_q, 8'hC9);
    @(negedge clk);
    check(!fifo_rst_rx && !fifo_rst_tx, "R8 pulses clear", {6'd0, fifo_rst_tx, fifo_rst_rx}, 8'h00);
    // R3 divisor bank
    wr(3'd3, 8'h80);
    wr(3'd0, 8'h34);
    check(tx_push == 1'b0, "R3 no tx push", {7'd0, tx_push}, 8'h00);
    wr(3'd1, 8'h12);
    check(ier_q == 8'h0F, "R3 ier untouched", ier_q, 8'h0F);
    check(dll_q == 8'h34 && dlh_q == 8'h12, "R3 divisor outputs", dlh_q, 8'h12);
    rd(3'd0, 8'h34, "R3 dll read");
    rd(3'd1, 8'h12, "R3 dlh read");
    // R5 alternate function
    rd(3'd2, 8'h10, "R5 afr read");
    wr(3'd2, 8'h55);
    rd(3'd2, 8'h55, "R5 afr write");
    // R4 magic bank
    wr(3'd3, 8'hBF);
    wr(3'd2, 8'h10);
    wr(3'd4, 8'h11); wr(3'd5, 8'h22); wr(3'd6, 8'h33); wr(3'd7, 8'h44);
    rd(3'd2, 8'h10, "R4 efr read");
    rd(3'd3, 8'hBF, "R4 lcr read");
    rd(3'd4, 8'h11, "R4 xon1");
    rd(3'd5, 8'h22, "R4 xon2");
    rd(3'd6, 8'h33, "R4 xoff1");
    rd(3'd7, 8'h44, "R4 xoff2");
    check(mcr_q == 8'h00, "R4 mcr untouched", mcr_q, 8'h00);
    // R7 guards open; R6 TCR/TLR bank
    wr(3'd3, 8'h03);
    wr(3'd1, 8'hFF);
    rd(3'd1, 8'hFF, "R7 ier open");
    wr(3'd4, 8'h40);
    rd(3'd4, 8'h40, "R7 mcr open");
    rd(3'd6, 8'h00, "R6 tcr reset");
    wr(3'd6, 8'h66); wr(3'd7, 8'h77);
    rd(3'd6, 8'h66, "R6 tcr read");
    rd(3'd7, 8'h77, "R6 tlr read");
    check(tcr_q == 8'h66 && tlr_q == 8'h77, "R6 tcr tlr outputs", tlr_q, 8'h77);
    // R9 fractional divisor wins address 7
    wr(3'd3, 8'h83);
    wr(3'd7, 8'hFF);
    rd(3'd7, 8'hBF, "R9 dlf reserved bit");
    check(tlr_q == 8'h77, "R9 tlr untouched", tlr_q, 8'h77);
    wr(3'd3, 8'h03);
    wr(3'd4, 8'h44);
    rd(3'd7, 8'h77, "R9 tlr over fifo ready");
    wr(3'd4, 8'h04);
    rd(3'd7, 8'h11, "R10 fifo ready over scratch");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule